// File: doc/BRIEF.md
# Byte DMA Channel with Grouped Source Rewind

This block is one DMA channel. It copies single bytes from a peripheral data register into memory. Software programs a source start address, a destination address, a transfer total and a control word. A one-cycle request pulse from the peripheral, typically a converter that has a fresh sample, starts a run of transfers. Each transfer is a read bus cycle at the source address followed by a write bus cycle at the destination address. Each bus cycle waits for its own ready handshake.

With rewind mode off, the channel holds the bus and runs every remaining transfer back to back. Both addresses climb by one per byte. With rewind mode on, the channel moves one group of four bytes per request. After the fourth byte of a group, the source address snaps back to its programmed start, the bus request drops, and the channel waits for the next request. The destination keeps climbing in both modes. For example, a total of 128 with rewind on gives 32 groups, so a four-register peripheral window can be sampled repeatedly into a linear buffer.

When the total runs out, the channel clears its enable bit, sets a done flag, and raises its interrupt line. It then ignores requests until software writes the control word again.

Top module: `dma_reload_chan`

## Requirements
- R1: After reset, all four registers read zero, and `irq`, `bus_req`, `m_rd` and `m_wr` are low.
- R2: Each transfer drives `m_rd` with `m_addr` equal to the current source address until `m_ready`. It then drives `m_wr` with `m_addr` equal to the current destination address and `m_wdata` equal to the byte captured at the read's ready cycle, until `m_ready`.
- R3: With rewind off (control bit 1 = 0), the source address rises by exactly 1 per completed transfer for the whole run, past every multiple of four.
- R4: With rewind on (control bit 1 = 1), the fourth transfer of each group leaves the source address equal to its programmed start, so transfer k reads start + (k mod 4).
- R5: The destination address rises by exactly 1 per completed transfer in both modes.
- R6: With rewind off, one request keeps `bus_req` high from the first read until the total is exhausted. A new read begins in the cycle after each write completes.
- R7: With rewind on, `bus_req` falls after the fourth write of a group, and no further transfer starts without a request. A run of N bytes therefore takes ceil(N/4) bus ownerships.
- R8: A request is ignored while control bit 0 (enable) is clear, including after completion.
- R9: A request that arrives while a group is active is held. The next group starts after the release, with `bus_req` low for exactly one cycle.
- R10: When the remaining count reaches zero, enable clears, done (control bit 2) sets, and `irq` rises. Any write to the control register clears done and `irq`.
- R11: Register writes are discarded while a group holds the bus.
- R12: Register offsets are: 0 source (a write sets both start and current; a read returns current), 1 destination, 2 remaining count, 3 control {done, rewind, enable} in bits 2..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| trig | input | 1 | Peripheral transfer request pulse |
| bus_req | output | 1 | Bus ownership request, held over a group |
| m_rd | output | 1 | Read cycle active |
| m_wr | output | 1 | Write cycle active |
| m_addr | output | AW | Bus address |
| m_wdata | output | 8 | Write data byte |
| m_rdata | input | 8 | Read data byte |
| m_ready | input | 1 | Bus cycle completes this edge |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
The bench builds the channel with 32-bit addresses, a 16-bit counter and a group size of four. These values bring both a 128-byte, 32-group run and a start address whose groups cross a 24-bit carry within a short run. Run lengths that are not a multiple of four reach the partial last group. Wait states from zero to three cycles stretch each bus cycle, which opens the window for a held request and for a discarded register write during an active group.

// File: rtl/dmarl_pkg.sv
package dmarl_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } seq_st_e;

    localparam logic [1:0] OFS_SRC = 2'd0;
    localparam logic [1:0] OFS_DST = 2'd1;
    localparam logic [1:0] OFS_CNT = 2'd2;
    localparam logic [1:0] OFS_CTL = 2'd3;

    localparam int CTL_EN   = 0;
    localparam int CTL_RW   = 1;
    localparam int CTL_DONE = 2;

    typedef struct packed {
        logic step;
        logic rewind;
    } step_t;

    function automatic int grp_bits(input int g);
        return (g > 1) ? $clog2(g) : 1;
    endfunction
endpackage

// File: rtl/dmarl_addr.sv
module dmarl_addr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_src,
    input  logic          ld_dst,
    input  logic [AW-1:0] wdata,
    input  dmarl_pkg::step_t st,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst
);
    logic [AW-1:0] start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            src     <= '0;
            dst     <= '0;
        end else begin
            if (ld_src) begin
                start_q <= wdata;
                src     <= wdata;
            end else if (st.step) begin
                src <= st.rewind ? start_q : src + AW'(1);
            end
            if (ld_dst) dst <= wdata;
            else if (st.step) dst <= dst + AW'(1);
        end
    end

    a_r5_dst_step: assert property (@(posedge clk) disable iff (rst)
        (st.step && !ld_dst) |=> dst == $past(dst) + AW'(1));
    a_r3_src_step: assert property (@(posedge clk) disable iff (rst)
        (st.step && !st.rewind && !ld_src) |=> src == $past(src) + AW'(1));
    a_r4_src_rewind: assert property (@(posedge clk) disable iff (rst)
        (st.step && st.rewind && !ld_src) |=> src == start_q);
endmodule

// File: rtl/dmarl_ctrl.sv
module dmarl_ctrl #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_cnt,
    input  logic          ld_ctl,
    input  logic [CW-1:0] wcnt,
    input  logic [1:0]    wctl,
    input  logic          step,
    output logic [CW-1:0] cnt,
    output logic          enable,
    output logic          reload,
    output logic          done,
    output logic          last,
    output logic          cnt_nz
);
    assign last   = (cnt == CW'(1));
    assign cnt_nz = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            enable <= 1'b0;
            reload <= 1'b0;
            done   <= 1'b0;
        end else begin
            if (ld_cnt) cnt <= wcnt;
            else if (step) cnt <= cnt - CW'(1);
            if (ld_ctl) begin
                enable <= wctl[0];
                reload <= wctl[1];
                done   <= 1'b0;
            end else if (step && last) begin
                enable <= 1'b0;
                done   <= 1'b1;
            end
        end
    end

    a_r10_done_disables: assert property (@(posedge clk) disable iff (rst)
        done |-> !enable);
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done && !ld_ctl) |=> done);
    a_r10_count_falls: assert property (@(posedge clk) disable iff (rst)
        (!ld_cnt && !step) |=> $stable(cnt));
endmodule

// File: rtl/dmarl_seq.sv
module dmarl_seq #(
    parameter int GRP = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             enable,
    input  logic             reload,
    input  logic             cnt_nz,
    input  logic             last,
    input  logic             m_ready,
    input  dmarl_pkg::byte_t m_rdata,
    output logic             bus_req,
    output logic             m_rd,
    output logic             m_wr,
    output logic             busy,
    output dmarl_pkg::step_t st,
    output dmarl_pkg::byte_t wbyte
);
    import dmarl_pkg::*;

    localparam int GW = grp_bits(GRP);
    localparam logic [GW-1:0] GLAST = GW'(GRP - 1);

    seq_st_e       state;
    logic          pend;
    logic [GW-1:0] grp;
    logic          go, wr_done, grp_end;

    assign m_rd    = (state == ST_RD);
    assign m_wr    = (state == ST_WR);
    assign busy    = (state != ST_IDLE);
    assign bus_req = busy;
    assign go      = (state == ST_IDLE) && enable && cnt_nz && (trig || pend);
    assign wr_done = m_wr && m_ready;
    assign grp_end = reload && (grp == GLAST);
    assign st.step   = wr_done;
    assign st.rewind = wr_done && grp_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pend  <= 1'b0;
            grp   <= '0;
            wbyte <= '0;
        end else begin
            if (busy && trig && enable && !(wr_done && last)) pend <= 1'b1;
            else if (go || (wr_done && last)) pend <= 1'b0;

            unique case (state)
                ST_IDLE: if (go) state <= ST_RD;
                ST_RD: if (m_ready) begin
                    wbyte <= m_rdata;
                    state <= ST_WR;
                end
                ST_WR: if (m_ready) begin
                    grp   <= (last || grp == GLAST) ? '0 : grp + GW'(1);
                    state <= (last || grp_end) ? ST_IDLE : ST_RD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r2_rd_hold: assert property (@(posedge clk) disable iff (rst)
        (m_rd && !m_ready) |=> m_rd);
    a_r2_wr_follows_rd: assert property (@(posedge clk) disable iff (rst)
        (m_rd && m_ready) |=> (m_wr && wbyte == $past(m_rdata)));
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (wr_done && grp_end) |=> !bus_req);
    a_r6_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (wr_done && !reload && !last) |=> m_rd);
    a_r8_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
        (!busy && !enable) |=> !bus_req);
endmodule

// File: rtl/dma_reload_chan.sv
module dma_reload_chan #(
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int GRP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          trig,
    output logic          bus_req,
    output logic          m_rd,
    output logic          m_wr,
    output logic [AW-1:0] m_addr,
    output logic [7:0]    m_wdata,
    input  logic [7:0]    m_rdata,
    input  logic          m_ready,
    output logic          irq
);
    import dmarl_pkg::*;

    logic          busy, wr_ok;
    logic [AW-1:0] src, dst;
    logic [CW-1:0] cnt;
    logic          enable, reload, done, last, cnt_nz;
    step_t         st;
    byte_t         wbyte;

    assign wr_ok = reg_wr && !busy;

    dmarl_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst(rst),
        .ld_src(wr_ok && reg_addr == OFS_SRC),
        .ld_dst(wr_ok && reg_addr == OFS_DST),
        .wdata(reg_wdata), .st(st), .src(src), .dst(dst)
    );

    dmarl_ctrl #(.CW(CW)) u_ctrl (
        .clk(clk), .rst(rst),
        .ld_cnt(wr_ok && reg_addr == OFS_CNT),
        .ld_ctl(wr_ok && reg_addr == OFS_CTL),
        .wcnt(reg_wdata[CW-1:0]), .wctl(reg_wdata[1:0]),
        .step(st.step), .cnt(cnt), .enable(enable), .reload(reload),
        .done(done), .last(last), .cnt_nz(cnt_nz)
    );

    dmarl_seq #(.GRP(GRP)) u_seq (
        .clk(clk), .rst(rst), .trig(trig), .enable(enable),
        .reload(reload), .cnt_nz(cnt_nz), .last(last),
        .m_ready(m_ready), .m_rdata(m_rdata), .bus_req(bus_req),
        .m_rd(m_rd), .m_wr(m_wr), .busy(busy), .st(st), .wbyte(wbyte)
    );

    assign m_addr  = m_rd ? src : dst;
    assign m_wdata = wbyte;
    assign irq     = done;

    always_comb begin
        unique case (reg_addr)
            OFS_SRC: reg_rdata = src;
            OFS_DST: reg_rdata = dst;
            OFS_CNT: reg_rdata = AW'(cnt);
            default: reg_rdata = AW'({done, reload, enable});
        endcase
    end

    a_r11_no_write_busy: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && busy && reg_addr == OFS_DST && !m_ready) |=> $stable(dst));
    a_r10_irq_at_end: assert property (@(posedge clk) disable iff (rst)
        (m_wr && m_ready && cnt == CW'(1)) |=> irq);
endmodule

// File: tb/test_dma_reload_chan.sv
module test_dma_reload_chan;
    localparam int AW = 32;
    localparam int CW = 16;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [15:0] cnt;
        logic        rw;
        logic [1:0]  wt;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{src: 32'hFFFF_85F0, dst: 32'h0000_E800, cnt: 16'd8,   rw: 1'b1, wt: 2'd0},
        '{src: 32'h0000_0100, dst: 32'h0000_2000, cnt: 16'd6,   rw: 1'b0, wt: 2'd1},
        '{src: 32'h00FF_FFFE, dst: 32'h0000_3000, cnt: 16'd10,  rw: 1'b1, wt: 2'd2},
        '{src: 32'h0000_0040, dst: 32'h0000_5000, cnt: 16'd128, rw: 1'b1, wt: 2'd0},
        '{src: 32'h0000_0080, dst: 32'h0000_7000, cnt: 16'd9,   rw: 1'b0, wt: 2'd3}
    };

    logic          clk = 0, rst = 1;
    logic          reg_wr = 0;
    logic [1:0]    reg_addr = 0;
    logic [AW-1:0] reg_wdata = 0, reg_rdata;
    logic          trig = 0, bus_req, m_rd, m_wr, m_ready, irq;
    logic [AW-1:0] m_addr;
    logic [7:0]    m_wdata, m_rdata;

    int unsigned total = 0, bad = 0;
    logic [1:0]  wait_cfg = 0;
    logic [1:0]  wcnt = 0;
    logic        clr_log = 0, bus_q = 0;
    int          nrd = 0, nwr = 0, rises = 0;
    logic [AW-1:0] rd_log [256];
    logic [AW-1:0] wa_log [256];
    logic [7:0]    wd_log [256];

    always #10 clk = ~clk;

    dma_reload_chan #(.AW(AW), .CW(CW), .GRP(4)) i_dma_reload_chan (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig(trig),
        .bus_req(bus_req), .m_rd(m_rd), .m_wr(m_wr), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready), .irq(irq)
    );

    assign m_rdata = m_addr[7:0] ^ 8'hA5;
    assign m_ready = (m_rd || m_wr) && (wcnt == wait_cfg);

    always @(posedge clk) begin
        wcnt  <= ((m_rd || m_wr) && !m_ready) ? wcnt + 2'd1 : 2'd0;
        bus_q <= bus_req;
        if (clr_log) begin
            nrd <= 0; nwr <= 0; rises <= 0;
        end else begin
            if (bus_req && !bus_q) rises <= rises + 1;
            if (m_rd && m_ready && nrd < 256) begin
                rd_log[nrd] <= m_addr; nrd <= nrd + 1;
            end
            if (m_wr && m_ready && nwr < 256) begin
                wa_log[nwr] <= m_addr; wd_log[nwr] <= m_wdata; nwr <= nwr + 1;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [AW-1:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [AW-1:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic pulse;
        @(negedge clk); trig = 1;
        @(negedge clk); trig = 0;
    endtask

    task automatic clear_log;
        @(negedge clk); clr_log = 1;
        @(negedge clk); clr_log = 0;
    endtask

    task automatic wait_low;
        int g = 0;
        while (bus_req && g < 5000) begin @(negedge clk); g++; end
    endtask

    task automatic run_vec(input vec_t v, input string req);
        logic [AW-1:0] d;
        int errs, grps, guard, k;
        logic [AW-1:0] exp_s;
        wait_cfg = v.wt;
        wreg(2'd0, v.src); wreg(2'd1, v.dst); wreg(2'd2, AW'(v.cnt));
        clear_log();
        wreg(2'd3, AW'({v.rw, 1'b1}));
        guard = 0;
        while (!irq && guard < 200) begin pulse(); wait_low(); guard++; end
        @(negedge clk);
        chk(nwr == int'(v.cnt), "R10", "write count", nwr, v.cnt);
        errs = 0; k = 0;
        for (int i = 0; i < int'(v.cnt) && i < nwr; i++) begin
            exp_s = v.rw ? v.src + AW'(i % 4) : v.src + AW'(i);
            if (rd_log[i] != exp_s) begin errs++; k = i; end
        end
        chk(errs == 0, v.rw ? "R4" : "R3", "source sequence", rd_log[k],
            v.rw ? v.src + AW'(k % 4) : v.src + AW'(k));
        errs = 0; k = 0;
        for (int i = 0; i < int'(v.cnt) && i < nwr; i++)
            if (wa_log[i] != v.dst + AW'(i)) begin errs++; k = i; end
        chk(errs == 0, "R5", "destination sequence", wa_log[k], v.dst + AW'(k));
        errs = 0; k = 0;
        for (int i = 0; i < int'(v.cnt) && i < nwr && i < nrd; i++)
            if (wd_log[i] != (rd_log[i][7:0] ^ 8'hA5)) begin errs++; k = i; end
        chk(errs == 0, "R2", "data copied", wd_log[k], rd_log[k][7:0] ^ 8'hA5);
        grps = v.rw ? (int'(v.cnt) + 3) / 4 : 1;
        chk(rises == grps, v.rw ? "R7" : "R6", "bus ownerships", rises, grps);
        rreg(2'd0, d);
        exp_s = v.rw ? v.src + AW'(v.cnt % 4) : v.src + AW'(v.cnt);
        chk(d == exp_s, "R12", "final source", d, exp_s);
        rreg(2'd1, d);
        chk(d == v.dst + AW'(v.cnt), "R12", "final destination", d, v.dst + AW'(v.cnt));
        rreg(2'd2, d);
        chk(d == 0, "R12", "final count", d, 0);
        rreg(2'd3, d);
        chk(d == AW'({1'b1, v.rw, 1'b0}), "R10", "control after end", d, {1'b1, v.rw, 1'b0});
        chk(irq == 1'b1, req, "irq after end", irq, 1);
    endtask

    initial begin
        #(20ns * 190000);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] d;
        int r0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rreg(2'(a), d);
            chk(d == 0, "R1", "register after reset", d, 0);
        end
        chk({irq, bus_req, m_rd, m_wr} == 4'b0, "R1", "outputs after reset",
            {irq, bus_req, m_rd, m_wr}, 0);

        // R8 request while never enabled
        wreg(2'd0, 32'h10); wreg(2'd1, 32'h20); wreg(2'd2, 32'd4);
        clear_log();
        pulse(); repeat (4) @(negedge clk);
        chk(rises == 0 && !bus_req, "R8", "request with enable clear", rises, 0);

        for (int i = 0; i < 5; i++) run_vec(VECS[i], "R10");

        // R8 request after completion
        r0 = rises;
        pulse(); repeat (4) @(negedge clk);
        chk(rises == r0 && !bus_req, "R8", "request after done", rises, r0);

        // R10 control write clears done
        wreg(2'd3, 32'd0);
        @(negedge clk);
        chk(irq == 1'b0, "R10", "irq cleared by control write", irq, 0);

        // R9 held request, R11 write during active group
        wait_cfg = 2'd2;
        wreg(2'd0, 32'h600); wreg(2'd1, 32'h8000); wreg(2'd2, 32'd8);
        clear_log();
        wreg(2'd3, 32'h3);
        pulse();
        chk(bus_req == 1'b1, "R9", "group started", bus_req, 1);
        pulse();
        wreg(2'd1, 32'hDEAD);
        wait_low();
        chk(bus_req == 1'b0, "R9", "released after group", bus_req, 0);
        @(negedge clk);
        chk(bus_req == 1'b1, "R9", "held request served", bus_req, 1);
        wait_low();
        @(negedge clk);
        chk(nwr == 8 && rises == 2, "R9", "two groups from held request", nwr, 8);
        rreg(2'd1, d);
        chk(d == 32'h8008, "R11", "destination ignores busy write", d, 32'h8008);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule